// File: doc/BRIEF.md
# Serial Bit Clock Prescaler Chain

This block derives the bit clock of a synchronous serial port from the system oscillator clock. The path runs through a fixed divide-by-four. A divide-by-eight stage can be switched in or out of the path. The last stage is an 8-bit programmable divider. Every divider is a clock enable in the oscillator domain, so the bit clock appears as a one-cycle bit enable. A level for the clock pin goes with it and toggles once per half bit period.

A word divider counts bit events and strobes on the last bit of each word. The word length is 8, 12, 16 or 24 bits. A clock-direction input selects the bit events the word divider counts. They come either from the internal chain or from an externally supplied, already synchronised bit-enable pulse. With the external source the clock pin level is held low.

Top module: `sbc_prescaler_chain`

## Requirements
- R1: With range_i=0 and modulus_i=0, internal bit events (bit_en_o) occur every 4 oscillator cycles.
- R2: With range_i=0, the internal bit period is 4*(modulus_i+1) oscillator cycles.
- R3: With range_i=1, the internal bit period is 32*(modulus_i+1) cycles. At modulus_i=255 this is 8192 cycles.
- R4: With int_clk_i=1, sck_o rises in the cycle after each bit event and stays high for exactly half the bit period.
- R5: word_o pulses together with the last bit event of each word, once every N bit events. N comes from wlen_i: 00=8, 01=12, 10=16, 11=24.
- R6: With int_clk_i=0, bit_en_o equals ext_bit_en_i, sck_o stays 0, and the word divider counts the external pulses.
- R7: While rst_ni is low, bit_en_o, sck_o and word_o are 0 when int_clk_i=1. After reset, the first word_o comes on the N-th bit event.
- R8: If modulus_i is lowered below the programmable divider's current count, the divider wraps at its next enable instead of running on to its full range. The next bit event then arrives within 12 cycles for a new modulus of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| range_i | input | 1 | 1 inserts the divide-by-eight stage |
| modulus_i | input | 8 | Programmable divider modulus M, divides by M+1 |
| wlen_i | input | 2 | Word length code |
| int_clk_i | input | 1 | 1 selects the internal bit clock, 0 the external one |
| ext_bit_en_i | input | 1 | External bit-enable pulse, synchronous to clk_i |
| bit_en_o | output | 1 | One-cycle bit event |
| sck_o | output | 1 | Bit clock level for the clock pin |
| word_o | output | 1 | Last-bit-of-word strobe |

## Verification
The assertions assume three things about the inputs. ext_bit_en_i is a single-cycle pulse with at least one idle cycle between pulses. int_clk_i changes only around reset. Word lengths are at least 8, so two word strobes are never adjacent. The bench keeps to these assumptions: it switches the clock source only just before asserting reset, and it drives external pulses on alternate cycles. The configuration table covers both range settings, the smallest and largest moduli and every word-length code, and a directed case lowers the modulus while the divider is running.

// File: rtl/sbc_pkg.sv
package sbc_pkg;
  localparam int WCNT_W = 5;

  typedef enum logic [1:0] {
    WL_8  = 2'b00,
    WL_12 = 2'b01,
    WL_16 = 2'b10,
    WL_24 = 2'b11
  } wlen_e;

  // last count index of a word (bits per word minus one)
  function automatic logic [WCNT_W-1:0] wl_last(input logic [1:0] code);
    case (wlen_e'(code))
      WL_8:    wl_last = WCNT_W'(7);
      WL_12:   wl_last = WCNT_W'(11);
      WL_16:   wl_last = WCNT_W'(15);
      default: wl_last = WCNT_W'(23);
    endcase
  endfunction
endpackage

// File: rtl/sbc_tick_div.sv
// Enable-driven modulo counter: tick when enabled at or beyond the last count.
module sbc_tick_div #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic [W-1:0] last_i,
  output logic         tick_o
);
  logic [W-1:0] cnt_q, cnt_d;
  logic         at_end;

  // >= so that a lowered limit wraps at once
  assign at_end = (cnt_q >= last_i);
  assign tick_o = en_i && at_end && !clr_i;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)       cnt_d = '0;
    else if (en_i)   cnt_d = at_end ? '0 : cnt_q + W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sbc_bit_level.sv
// Half-period toggle: turns half-bit ticks into a pin level and a bit event.
module sbc_bit_level (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic half_i,
  output logic lvl_o,
  output logic bit_o
);
  logic lvl_q, lvl_d;

  assign bit_o = half_i && !lvl_q;
  assign lvl_o = lvl_q;

  always_comb begin
    lvl_d = lvl_q;
    if (half_i) lvl_d = !lvl_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) lvl_q <= 1'b0;
    else         lvl_q <= lvl_d;
  end
endmodule

// File: rtl/sbc_prescaler_chain.sv
module sbc_prescaler_chain #(
  parameter int MOD_W     = 8,
  parameter int RANGE_DIV = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             range_i,
  input  logic [MOD_W-1:0] modulus_i,
  input  logic [1:0]       wlen_i,
  input  logic             int_clk_i,
  input  logic             ext_bit_en_i,
  output logic             bit_en_o,
  output logic             sck_o,
  output logic             word_o
);
  import sbc_pkg::*;

  localparam int RW = (RANGE_DIV > 1) ? $clog2(RANGE_DIV) : 1;

  // reset: asynchronous assert, synchronous release
  logic rs1_q, rs2_q, rst_s_n;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rs1_q <= 1'b0;
      rs2_q <= 1'b0;
    end else begin
      rs1_q <= 1'b1;
      rs2_q <= rs1_q;
    end
  end
  assign rst_s_n = rs2_q;

  // fixed /2 (with the final level toggle this gives the fixed /4)
  logic fix_tick, pre_tick, half_tick, lvl, bit_int;

  sbc_tick_div #(.W(1)) u_fix (
    .clk_i(clk_i), .rst_ni(rst_s_n), .clr_i(1'b0), .en_i(1'b1),
    .last_i(1'b1), .tick_o(fix_tick)
  );

  generate
    if (RANGE_DIV > 1) begin : g_range
      logic rng_tick;
      sbc_tick_div #(.W(RW)) u_rng (
        .clk_i(clk_i), .rst_ni(rst_s_n), .clr_i(!range_i), .en_i(fix_tick),
        .last_i(RW'(RANGE_DIV - 1)), .tick_o(rng_tick)
      );
      assign pre_tick = range_i ? rng_tick : fix_tick;
    end else begin : g_norange
      assign pre_tick = fix_tick;
    end
  endgenerate

  sbc_tick_div #(.W(MOD_W)) u_prog (
    .clk_i(clk_i), .rst_ni(rst_s_n), .clr_i(1'b0), .en_i(pre_tick),
    .last_i(modulus_i), .tick_o(half_tick)
  );

  sbc_bit_level u_lvl (
    .clk_i(clk_i), .rst_ni(rst_s_n), .half_i(half_tick),
    .lvl_o(lvl), .bit_o(bit_int)
  );

  assign bit_en_o = int_clk_i ? bit_int : ext_bit_en_i;
  assign sck_o    = int_clk_i && lvl;

  sbc_tick_div #(.W(WCNT_W)) u_word (
    .clk_i(clk_i), .rst_ni(rst_s_n), .clr_i(1'b0), .en_i(bit_en_o),
    .last_i(wl_last(wlen_i)), .tick_o(word_o)
  );
endmodule

// File: rtl/sbc_prescaler_chain_chk.sv
module sbc_prescaler_chain_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic int_clk_i,
  input logic bit_en_o,
  input logic sck_o,
  input logic word_o
);
  // R6: clock pin is quiet when the external source is selected
  a_r6_pin_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !int_clk_i |-> !sck_o);

  // R5: a word strobe only comes with a bit event
  a_r5_word_on_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_o |-> bit_en_o);

  // R4: level rises right after an internal bit event
  a_r4_rise_after_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_clk_i && bit_en_o) |=> (sck_o || !int_clk_i));

  // R1: internal bit events are never back to back
  a_r1_min_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_clk_i && bit_en_o) |=> !(int_clk_i && bit_en_o));

  // R5: words are at least eight bits apart, never adjacent
  a_r5_word_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    word_o |=> !word_o);
endmodule

bind sbc_prescaler_chain sbc_prescaler_chain_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .int_clk_i(int_clk_i),
  .bit_en_o(bit_en_o), .sck_o(sck_o), .word_o(word_o)
);

// File: tb/sbc_prescaler_chain_tb.sv
module sbc_prescaler_chain_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       range_s = 1'b0;
  logic [7:0] mod_s = 8'd0;
  logic [1:0] wl_s = 2'd0;
  logic       intc = 1'b1;
  logic       ext = 1'b0;
  logic       bit_en, sck, word;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  sbc_prescaler_chain u_dut (
    .clk_i(clk), .rst_ni(rst_n), .range_i(range_s), .modulus_i(mod_s),
    .wlen_i(wl_s), .int_clk_i(intc), .ext_bit_en_i(ext),
    .bit_en_o(bit_en), .sck_o(sck), .word_o(word)
  );

  // {range, modulus, wlen, check_words}
  localparam int NV = 6;
  localparam logic [11:0] VEC [NV] = '{
    {1'b0, 8'd0,   2'd0, 1'b1},
    {1'b1, 8'd0,   2'd1, 1'b1},
    {1'b0, 8'd5,   2'd2, 1'b1},
    {1'b1, 8'd3,   2'd3, 1'b1},
    {1'b0, 8'd255, 2'd0, 1'b1},
    {1'b1, 8'd255, 2'd0, 1'b0}
  };

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int wl_bits(input logic [1:0] c);
    case (c)
      2'd0: return 8;
      2'd1: return 12;
      2'd2: return 16;
      default: return 24;
    endcase
  endfunction

  task automatic next_bit(output int n, output logic w);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!bit_en);
    w = word;
  endtask

  task automatic do_reset(input bit chk);
    @(negedge clk);
    rst_n = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      if (chk) check("R7 reset outputs", {29'd0, bit_en, sck, word}, 0);
    end
    rst_n = 1'b1;
  endtask

  initial begin
    #(20 * 190000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    int n, k, sum, p, wb, hi;
    logic w;
    string tg;

    for (int v = 0; v < NV; v++) begin
      range_s = VEC[v][11];
      mod_s   = VEC[v][10:3];
      wl_s    = VEC[v][2:1];
      intc    = 1'b1;
      p  = 4 * (range_s ? 8 : 1) * (int'(mod_s) + 1);
      wb = wl_bits(wl_s);
      tg = range_s ? "R3 bit period" : (mod_s == 0 ? "R1 bit period" : "R2 bit period");
      do_reset(1);
      if (VEC[v][0]) begin
        k = 0;
        do begin next_bit(n, w); k++; end while (!w);
        check("R7 first word bit count", k, wb);
        k = 0; sum = 0;
        do begin next_bit(n, w); k++; sum += n; end while (!w);
        check("R5 word bit count", k, wb);
        check("R5 word cycles", sum, wb * p);
      end else begin
        next_bit(n, w);
      end
      next_bit(n, w);
      check(tg, n, p);
      next_bit(n, w);
      check(tg, n, p);
      hi = 0;
      @(negedge clk);
      while (sck) begin hi++; @(negedge clk); end
      check("R4 high width", hi, p / 2);
    end

    // R6: external bit source
    intc = 1'b0; ext = 1'b0; wl_s = 2'd0;
    do_reset(0);
    repeat (4) @(negedge clk);
    for (int i = 1; i <= 8; i++) begin
      @(negedge clk);
      ext = 1'b1;
      #2;
      check("R6 bit follows ext", int'(bit_en), 1);
      check("R6 word on ext", int'(word), (i == 8) ? 1 : 0);
      @(negedge clk);
      ext = 1'b0;
      #2;
      check("R6 bit low", int'(bit_en), 0);
      check("R6 pin held low", int'(sck), 0);
    end
    repeat (40) begin
      @(negedge clk);
      if (sck) check("R6 pin quiet", 1, 0);
    end

    // R8: modulus lowered below the running count
    intc = 1'b1; range_s = 1'b0; mod_s = 8'd200;
    do_reset(0);
    next_bit(n, w);
    repeat (300) @(negedge clk);
    mod_s = 8'd1;
    next_bit(n, w);
    check("R8 wrap promptly", (n <= 12) ? 1 : 0, 1);
    next_bit(n, w);
    check("R8 new period", n, 8);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule